// File: doc/BRIEF.md
# PCM Serial Time-Slot Port

This block carries the serial 8-bit PCM words of a voice codec. On the transmit side a code word is taken in from a parallel input at the start of each transmit slot. The word taken in during the previous slot goes out bit by bit, sign bit first, on a data output with a separate output enable for a three-state pad. An active-low time-slot output is low for as long as that enable is high. On the receive side 8 bits are shifted in from the serial data input and handed over as a parallel word together with a one-cycle valid strobe.

Every pin is synchronous to one system clock. The bit clock and both frame syncs are plain inputs that are sampled on that clock, and their edges are found inside the block. The port handles both frame sync styles. A sync that is one bit clock wide selects short frame timing. A sync that is high on three or more falling bit-clock edges selects long frame timing. Only the transmit sync decides the style, and the result is available as a status output. A receive sync that is high on exactly two falling edges marks the received LSB as taken for signalling, so that a decoder can substitute one half of a step for it.

Top module: `pcm_slot_port`

## Requirements
- R1: After reset tx_oe and tx_load are 0, tslot_n is 1, rx_valid is 0 and long_mode is 0 (short frame timing).
- R2: Short timing on transmit. When a falling bit-clock edge sees tx_sync high, the next rising edge raises tx_oe and drives bit 7. Each of the next seven rising edges drives the next lower bit. The falling edge after the eighth rising edge clears tx_oe.
- R3: Short timing on receive. When a falling bit-clock edge sees rx_sync high, the next eight falling edges capture rx_din, MSB first. rx_word then presents the byte, and rx_valid is high for exactly one cycle.
- R4: long_mode is set once tx_sync has been high on 3 falling bit-clock edges. When tx_sync falls, long_mode is written with whether that count was reached. The width of rx_sync never changes long_mode.
- R5: Long timing on transmit. tx_oe rises and bit 7 is driven at the later of the tx_sync rising edge and a bit-clock rising edge. Bits 6 to 0 follow on the next seven rising edges.
- R6: Long timing on transmit. tx_oe clears at the later of two events: the falling edge after the eighth rising edge, and tx_sync going low.
- R7: Long timing on receive. A rising rx_sync starts capture on the next eight falling bit-clock edges, MSB first, ending with a one-cycle rx_valid.
- R8: tx_load pulses for one cycle as each transmit slot starts, and tx_code is sampled then. The word sent in a slot is the one sampled at the previous slot start, and the first slot after reset sends 8'h00.
- R9: tslot_n is low exactly while tx_oe is high.
- R10: rx_lsb_half, updated with each rx_valid, is 1 only when rx_sync was high on exactly 2 falling bit-clock edges before it fell in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bclk | input | 1 | Bit clock, sampled on clk |
| tx_sync | input | 1 | Transmit frame sync |
| rx_sync | input | 1 | Receive frame sync |
| rx_din | input | 1 | Serial receive data |
| tx_code | input | WORD_W | Code word for the next transmit slot |
| tx_load | output | 1 | One-cycle strobe when tx_code is taken |
| tx_dout | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Enable for the three-state transmit pad |
| tslot_n | output | 1 | Low during the transmit slot |
| rx_word | output | WORD_W | Last received word |
| rx_valid | output | 1 | One-cycle strobe for a new rx_word |
| rx_lsb_half | output | 1 | LSB of rx_word is a signalling bit |
| long_mode | output | 1 | 1 when long frame timing is in use |

## Verification
The hardest states to reach are the long-frame "whichever is later" cases. These are a sync that rises while the bit clock is already low, and a sync that stays high past the eighth bit or drops exactly at it. Frame widths of 8 and 10 bit clocks, and a delayed sync rise, are driven as directed frames. Random frames then mix short and long syncs of random width with random words. Frames that change the mode are used only to check the new mode and the word handover. The receive sync width is varied apart from the transmit width, which exercises the signalling flag and shows that the receive width leaves the mode alone.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;
  // transmit slot sequencing
  typedef enum logic [1:0] {
    TXS_IDLE,
    TXS_ARMED,
    TXS_SHIFT,
    TXS_DRAIN
  } tx_state_e;

  // lanes of the sampled-input edge detector
  localparam int EDGE_BCLK = 0;
  localparam int EDGE_TXS  = 1;
  localparam int EDGE_RXS  = 2;
  localparam int EDGE_N    = 3;
endpackage

// File: rtl/pcm_edge_det.sv
module pcm_edge_det #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic [N-1:0] level,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev;

  // follows the input even in reset, so edges are never invented
  always_ff @(posedge clk) prev <= level;

  for (genvar i = 0; i < N; i++) begin : g_lane
    assign rise[i] = level[i] & ~prev[i];
    assign fall[i] = ~level[i] & prev[i];
  end
endmodule

// File: rtl/pcm_sync_meter.sv
module pcm_sync_meter #(
  parameter int SAT_CNT = 3,
  localparam int CW = $clog2(SAT_CNT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          level,
  input  logic          start,
  output logic [CW-1:0] width
);
  // counts falling bit-clock edges seen while the sync is high, saturating
  always_ff @(posedge clk) begin
    if (rst) begin
      width <= '0;
    end else if (start) begin
      width <= CW'(tick);
    end else if (tick && level && width != CW'(SAT_CNT)) begin
      width <= width + 1'b1;
    end
  end
endmodule

// File: rtl/pcm_tx_slot.sv
module pcm_tx_slot
  import pcm_slot_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bclk,
  input  logic              bclk_rise,
  input  logic              bclk_fall,
  input  logic              sync,
  input  logic              sync_rise,
  input  logic              long_mode,
  input  logic [WORD_W-1:0] code,
  output logic              load,
  output logic              dout,
  output logic              oe,
  output logic              tslot_n
);
  localparam int BC_W = $clog2(WORD_W + 1);

  tx_state_e         state;
  logic [WORD_W-1:0] hold;
  logic [WORD_W-1:0] shreg;
  logic [BC_W-1:0]   sent;
  logic              done;
  logic              begin_now;
  logic              arm_now;
  logic              release_now;

  always_comb begin
    begin_now = 1'b0;
    arm_now   = 1'b0;
    case (state)
      TXS_IDLE: begin
        if (long_mode) begin
          // later of sync rise and bit-clock rise
          if (sync_rise) begin
            if (bclk) begin_now = 1'b1;
            else      arm_now   = 1'b1;
          end
        end else if (bclk_fall && sync) begin
          arm_now = 1'b1;
        end
      end
      TXS_ARMED: begin_now = bclk_rise;
      default: ;
    endcase
  end

  // later of "falling edge after last bit" and "sync low" in long timing
  assign release_now = (state == TXS_DRAIN) && (done || bclk_fall) &&
                       (!long_mode || !sync);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= TXS_IDLE;
      hold    <= '0;
      shreg   <= '0;
      sent    <= '0;
      done    <= 1'b0;
      load    <= 1'b0;
      dout    <= 1'b0;
      oe      <= 1'b0;
      tslot_n <= 1'b1;
    end else begin
      load <= 1'b0;
      if (begin_now) begin
        state   <= TXS_SHIFT;
        hold    <= code;
        shreg   <= {hold[WORD_W-2:0], 1'b0};
        dout    <= hold[WORD_W-1];
        sent    <= BC_W'(1);
        done    <= 1'b0;
        load    <= 1'b1;
        oe      <= 1'b1;
        tslot_n <= 1'b0;
      end else if (arm_now) begin
        state <= TXS_ARMED;
      end else if (state == TXS_SHIFT && bclk_rise) begin
        dout  <= shreg[WORD_W-1];
        shreg <= {shreg[WORD_W-2:0], 1'b0};
        sent  <= sent + 1'b1;
        if (sent == BC_W'(WORD_W - 1)) state <= TXS_DRAIN;
      end else if (release_now) begin
        state   <= TXS_IDLE;
        done    <= 1'b0;
        dout    <= 1'b0;
        oe      <= 1'b0;
        tslot_n <= 1'b1;
      end else if (state == TXS_DRAIN && bclk_fall) begin
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bclk_fall,
  input  logic              sync,
  input  logic              sync_rise,
  input  logic              long_mode,
  input  logic              din,
  input  logic              half_mark,
  output logic [WORD_W-1:0] word,
  output logic              valid,
  output logic              lsb_half
);
  localparam int CNT_W = $clog2(WORD_W);

  logic              run;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] shreg;
  logic              trig;

  assign trig = !run && (long_mode ? sync_rise : (bclk_fall && sync));

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      cnt      <= '0;
      shreg    <= '0;
      word     <= '0;
      valid    <= 1'b0;
      lsb_half <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (run && bclk_fall) begin
        shreg <= {shreg[WORD_W-2:0], din};
        if (cnt == CNT_W'(WORD_W - 1)) begin
          run      <= 1'b0;
          cnt      <= '0;
          word     <= {shreg[WORD_W-2:0], din};
          valid    <= 1'b1;
          lsb_half <= half_mark;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (trig) begin
        run <= 1'b1;
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
  import pcm_slot_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int LONG_MIN = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bclk,
  input  logic              tx_sync,
  input  logic              rx_sync,
  input  logic              rx_din,
  input  logic [WORD_W-1:0] tx_code,
  output logic              tx_load,
  output logic              tx_dout,
  output logic              tx_oe,
  output logic              tslot_n,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid,
  output logic              rx_lsb_half,
  output logic              long_mode
);
  localparam int CW        = $clog2(LONG_MIN + 1);
  localparam int ROB_WIDTH = 2;

  logic [EDGE_N-1:0] lvl;
  logic [EDGE_N-1:0] rise;
  logic [EDGE_N-1:0] fall;
  logic [CW-1:0]     width_q [2];
  logic              rob_mark;

  assign lvl = {rx_sync, tx_sync, bclk};

  pcm_edge_det #(.N(EDGE_N)) u_edges (
    .clk  (clk),
    .level(lvl),
    .rise (rise),
    .fall (fall)
  );

  // one width meter per frame sync (index 0 transmit, 1 receive)
  for (genvar g = 0; g < 2; g++) begin : g_meter
    pcm_sync_meter #(.SAT_CNT(LONG_MIN)) u_meter (
      .clk  (clk),
      .rst  (rst),
      .tick (fall[EDGE_BCLK]),
      .level(lvl[EDGE_TXS+g]),
      .start(rise[EDGE_TXS+g]),
      .width(width_q[g])
    );
  end

  // frame style follows the transmit sync width only
  always_ff @(posedge clk) begin
    if (rst) begin
      long_mode <= 1'b0;
    end else if (fall[EDGE_TXS]) begin
      long_mode <= (width_q[0] == CW'(LONG_MIN));
    end else if (width_q[0] == CW'(LONG_MIN)) begin
      long_mode <= 1'b1;
    end
  end

  // receive sync of exactly two bit clocks marks a signalling LSB
  always_ff @(posedge clk) begin
    if (rst) begin
      rob_mark <= 1'b0;
    end else if (rise[EDGE_RXS]) begin
      rob_mark <= 1'b0;
    end else if (fall[EDGE_RXS]) begin
      rob_mark <= (width_q[1] == CW'(ROB_WIDTH));
    end
  end

  pcm_tx_slot #(.WORD_W(WORD_W)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .bclk     (bclk),
    .bclk_rise(rise[EDGE_BCLK]),
    .bclk_fall(fall[EDGE_BCLK]),
    .sync     (tx_sync),
    .sync_rise(rise[EDGE_TXS]),
    .long_mode(long_mode),
    .code     (tx_code),
    .load     (tx_load),
    .dout     (tx_dout),
    .oe       (tx_oe),
    .tslot_n  (tslot_n)
  );

  pcm_rx_slot #(.WORD_W(WORD_W)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .bclk_fall(fall[EDGE_BCLK]),
    .sync     (rx_sync),
    .sync_rise(rise[EDGE_RXS]),
    .long_mode(long_mode),
    .din      (rx_din),
    .half_mark(rob_mark),
    .word     (rx_word),
    .valid    (rx_valid),
    .lsb_half (rx_lsb_half)
  );
endmodule

// File: rtl/pcm_slot_port_chk.sv
module pcm_slot_port_chk (
  input logic clk,
  input logic rst,
  input logic bclk,
  input logic tx_sync,
  input logic tx_load,
  input logic tx_dout,
  input logic tx_oe,
  input logic rx_valid,
  input logic long_mode
);
  // R3
  rx_valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R7
  rx_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (!$past(bclk) && $past(bclk, 2)));

  // R8
  load_opens_slot_chk: assert property (@(posedge clk) disable iff (rst)
    tx_load |-> $rose(tx_oe));

  // R2
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_oe && $past(tx_oe) && !($past(bclk) && !$past(bclk, 2))) |-> $stable(tx_dout));

  // R5
  oe_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_oe) |-> (($past(bclk) && !$past(bclk, 2)) ||
                      ($past(tx_sync) && !$past(tx_sync, 2) && $past(bclk))));

  // R6
  oe_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_oe) |-> ((!$past(bclk) && $past(bclk, 2)) || !$past(tx_sync)));

  // R4
  mode_change_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(long_mode) |-> ($past(tx_sync) || $past(tx_sync, 2)));
endmodule

bind pcm_slot_port pcm_slot_port_chk i_chk (.*);

// File: tb/test_pcm_slot_port.sv
module test_pcm_slot_port;
  localparam int H = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bclk = 1'b0;
  logic       tx_sync = 1'b0;
  logic       rx_sync = 1'b0;
  logic       rx_din = 1'b0;
  logic [7:0] tx_code = 8'h00;
  logic       tx_load, tx_dout, tx_oe, tslot_n;
  logic [7:0] rx_word;
  logic       rx_valid, rx_lsb_half, long_mode;

  always #2.5 clk = ~clk;

  pcm_slot_port i_pcm_slot_port (
    .clk(clk), .rst(rst), .bclk(bclk), .tx_sync(tx_sync), .rx_sync(rx_sync),
    .rx_din(rx_din), .tx_code(tx_code), .tx_load(tx_load), .tx_dout(tx_dout),
    .tx_oe(tx_oe), .tslot_n(tslot_n), .rx_word(rx_word), .rx_valid(rx_valid),
    .rx_lsb_half(rx_lsb_half), .long_mode(long_mode)
  );

  int         n_chk = 0;
  int         n_fail = 0;
  int         loads = 0;
  int         valids = 0;
  logic [7:0] got_word = 8'h00;
  logic       got_half = 1'b0;
  bit         model_long = 1'b0;
  logic [7:0] hold_m = 8'h00;

  always @(posedge clk) begin
    if (!rst && tx_load) loads++;
    if (!rst && rx_valid) begin
      valids++;
      got_word <= rx_word;
      got_half <= rx_lsb_half;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic half(input logic b, input logic ts, input logic rs, input logic d);
    @(negedge clk);
    bclk = b; tx_sync = ts; rx_sync = rs; rx_din = d;
    repeat (H - 1) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      half(1'b1, 1'b0, 1'b0, 1'b0);
      half(1'b0, 1'b0, 1'b0, 1'b0);
    end
  endtask

  function automatic bit exp_oe(bit lm, int c, int cc, int len, bit hi);
    if (lm) return (cc >= 0) && ((hi ? cc <= 7 : cc < 7) || cc < len);
    return (c >= 1) && (hi ? c <= 8 : c <= 7);
  endfunction

  // one frame: tx sync of width len (delayed by half a bit when late), rx sync of width lrx
  task automatic frame(input int len, input bit late, input int lrx,
                       input logic [7:0] code, input logic [7:0] rxw);
    bit         lm = model_long;
    bit         l_new = (len + int'(late)) >= 3;
    bit         chk = (lm == l_new);
    logic [7:0] sent = hold_m;
    int         l0 = loads;
    int         v0 = valids;
    int         last = (len + int'(late) > 9) ? len + int'(late) : 9;
    tx_code = code;
    for (int c = 0; c < last + 2; c++) begin
      logic ts_hi = late ? (c >= 1 && c <= len) : (c < len);
      logic ts_lo = late ? (c <= len) : (c < len);
      int   ridx = lm ? c : c - 1;
      logic d = (ridx >= 0 && ridx < 8) ? rxw[7-ridx] : 1'b0;
      int   cc = c - int'(late);
      int   bidx = lm ? cc : c - 1;
      bit   eo;
      half(1'b1, ts_hi, (c < lrx), d);
      if (chk) begin
        eo = exp_oe(lm, c, cc, len, 1'b1);
        check(tx_oe == eo, lm ? "R5" : "R2", "tx_oe after rise", tx_oe, eo);
        check(tslot_n == !eo, "R9", "tslot_n after rise", tslot_n, !eo);
        if (eo && bidx >= 0 && bidx < 8)
          check(tx_dout == sent[7-bidx], lm ? "R5" : "R2", "tx_dout bit", tx_dout, sent[7-bidx]);
      end
      half(1'b0, ts_lo, (c < lrx), d);
      if (chk) begin
        eo = exp_oe(lm, c, cc, len, 1'b0);
        check(tx_oe == eo, lm ? "R6" : "R2", "tx_oe after fall", tx_oe, eo);
        check(tslot_n == !eo, "R9", "tslot_n after fall", tslot_n, !eo);
      end
    end
    check(loads == l0 + 1, "R8", "tx_load pulses per slot", loads - l0, 1);
    check(long_mode == l_new, "R4", "long_mode after frame", long_mode, l_new);
    if (chk) begin
      check(valids == v0 + 1, lm ? "R7" : "R3", "rx_valid pulses", valids - v0, 1);
      check(got_word == rxw, lm ? "R7" : "R3", "rx_word", got_word, rxw);
      check(got_half == (lm && lrx == 2), "R10", "rx_lsb_half", got_half, (lm && lrx == 2));
    end
    hold_m = code;
    model_long = l_new;
  endtask

  initial begin
    void'($urandom(32'd5151));
    repeat (4) @(negedge clk);
    // R1 reset state
    check(tx_oe == 1'b0, "R1", "tx_oe in reset", tx_oe, 0);
    check(tslot_n == 1'b1, "R1", "tslot_n in reset", tslot_n, 1);
    rst = 1'b0;
    idle(2);
    check(long_mode == 1'b0, "R1", "long_mode after reset", long_mode, 0);
    check(rx_valid == 1'b0, "R1", "rx_valid after reset", rx_valid, 0);
    check(tx_load == 1'b0, "R1", "tx_load after reset", tx_load, 0);

    frame(1, 1'b0, 1, 8'hA5, 8'h3C);   // R8: first slot sends 00
    idle(2);
    frame(2, 1'b0, 1, 8'h81, 8'hC3);   // R4: width 2 stays short
    idle(2);
    frame(1, 1'b0, 3, 8'h7E, 8'h5A);   // R4: wide rx sync keeps short
    idle(2);
    frame(4, 1'b0, 1, 8'h01, 8'h00);   // switch to long
    idle(2);
    frame(3, 1'b0, 2, 8'hF0, 8'h96);   // R10 two-wide rx sync
    idle(2);
    frame(10, 1'b0, 3, 8'h0F, 8'h69);  // R6 sync outlasts last bit
    idle(2);
    frame(8, 1'b0, 1, 8'hAA, 8'h55);   // R6 sync drops at last bit
    idle(3);
    frame(3, 1'b1, 2, 8'h33, 8'hCC);   // R5 sync rises with bit clock low
    idle(2);
    frame(1, 1'b0, 1, 8'h44, 8'h22);   // back to short
    idle(2);
    frame(1, 1'b0, 1, 8'h99, 8'hE7);

    for (int n = 0; n < 200; n++) begin
      bit   want_long = $urandom_range(1, 0) == 1;
      int   len = want_long ? int'($urandom_range(11, 3)) : int'($urandom_range(2, 1));
      bit   late = want_long && model_long && ($urandom_range(3, 0) == 0);
      int   lrx = model_long ? int'($urandom_range(4, 1)) : 1;
      frame(len, late, lrx, 8'($urandom), 8'($urandom));
      idle(int'($urandom_range(4, 2)));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule